// File: doc/BRIEF.md
# Buffered Peripheral-to-Memory DMA Engine

This block moves a stream of data from a peripheral into memory. A rising edge on the request input starts one fixed 8-byte read from the peripheral. Each read appends its bytes to a 32-byte internal staging buffer. Memory writes drain the buffer in whole 32-byte bursts.

The first write of a run is cut short when needed, so that every write after it begins on a 32-byte boundary. The run ends in one of two ways. Either the programmed byte count runs out, or the peripheral pulls its end line low. In both cases whatever is still buffered goes out in one final write, and a sticky status bit records why the channel stopped.

A masked OR of the status bits drives the interrupt line. Once stopped, the channel ignores requests until the next start pulse.

Top module: `p2m_dma`

## Requirements
- R1: Every rising edge of `req_i` seen while running produces exactly one one-cycle `prd_en_o` pulse. In that cycle `prd_data_i` is taken as 8 bytes, byte j on bits [8j+7:8j]. A read and a memory write never share a cycle.
- R2: Call the start address A (a multiple of 8). The first memory write issues once 4 reads have filled 32 bytes. Its size is 32 - (A mod 32), so it is 32 when A is burst-aligned.
- R3: When the buffer holds 32 bytes and length remains, a write follows at once. Every write after the first non-final write is 32 bytes. Write sizes are always non-zero multiples of 8, at most 32.
- R4: The memory address starts at A and grows by the size of each write. Bytes reach memory in arrival order, the first byte of a write on `mwr_data_o[7:0]`.
- R5: The length (bytes, a multiple of 8) is counted down by 8 on each read. When it reaches zero, all buffered bytes go out in one write. Then status bit 0 (stopped) and bit 2 (length complete) are set, and the channel stops.
- R6: A falling edge on `done_ni` while running flushes the buffer in one write, once any write in progress has ended. Then status bits 0 and 1 (peripheral end) are set and the channel stops. Later requests cause no reads or writes until `start_i`.
- R7: Status bits reset to 0, stay set until a one is written to the same position of `sts_clr_i`, and `irq_o` is the OR of `sts_o & irq_mask_i`. Each source masks on its own, so a set stopped bit with its mask bit clear leaves `irq_o` low.
- R8: A memory write holds the bus for WR_CYC cycles (default 3). No read or write starts in that window. Requests arriving then are queued and each is served exactly once afterwards.
- R9: A request line held high produces one read only. A rising edge on `done_ni`, or a low level already present at start, has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken only while stopped |
| addr_i | input | AW | Start memory address, 8-byte aligned |
| len_i | input | LEN_W | Transfer length in bytes, non-zero multiple of 8 |
| req_i | input | 1 | Peripheral request, rising-edge sensitive |
| done_ni | input | 1 | Peripheral end of data, falling-edge sensitive |
| prd_en_o | output | 1 | Peripheral read strobe |
| prd_data_i | input | RD_BYTES*8 | Peripheral read data |
| mwr_valid_o | output | 1 | Memory write issue strobe |
| mwr_addr_o | output | AW | Memory write address |
| mwr_size_o | output | FILL_W | Memory write size in bytes |
| mwr_data_o | output | BUF_BYTES*8 | Memory write data, first byte lowest |
| irq_mask_i | input | 3 | Per-source interrupt enable |
| sts_clr_i | input | 3 | Write-one-to-clear for status bits |
| sts_o | output | 3 | Status: bit0 stopped, bit1 peripheral end, bit2 length complete |
| irq_o | output | 1 | Masked interrupt |

## Verification
The assertions take the configuration to be well formed. The start address and length must be multiples of 8, the length non-zero, and a start pulse must come only after the previous run has stopped. The address-continuity and quiet-after-stop properties also need the status bits cleared before a restart. The stimulus keeps to this: it issues each start only after seeing the stopped bit, and it clears status in between. It picks aligned and unaligned addresses that are all multiples of 8. It spaces request edges so the pending count stays far below its limit.

// File: rtl/p2m_dma_pkg.sv
package p2m_dma_pkg;
  localparam int unsigned STS_W   = 3;
  localparam int unsigned ST_STOP = 0;
  localparam int unsigned ST_XEND = 1;
  localparam int unsigned ST_LEN  = 2;
  typedef logic [STS_W-1:0] sts_t;
endpackage

// File: rtl/p2m_edge_det.sv
module p2m_edge_det #(
  parameter bit RISE = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic pulse_o
);
  logic q;

  generate
    if (RISE) begin : g_rise
      // reset high: a line already high after reset is not an edge
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= 1'b1;
        else         q <= sig_i;
      end
      assign pulse_o = sig_i & ~q;
    end else begin : g_fall
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= 1'b0;
        else         q <= sig_i;
      end
      assign pulse_o = ~sig_i & q;
    end
  endgenerate
endmodule

// File: rtl/p2m_pack_buf.sv
module p2m_pack_buf #(
  parameter int unsigned RD_BYTES  = 8,
  parameter int unsigned BUF_BYTES = 32,
  localparam int unsigned FILL_W   = $clog2(BUF_BYTES + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      clear_i,
  input  logic                      push_i,
  input  logic [RD_BYTES*8-1:0]     push_data_i,
  input  logic                      pop_i,
  input  logic [FILL_W-1:0]         pop_size_i,
  output logic [FILL_W-1:0]         fill_o,
  output logic [BUF_BYTES*8-1:0]    data_o
);
  logic [7:0]        mem_q [BUF_BYTES];
  logic [FILL_W-1:0] fill_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q <= '0;
      for (int i = 0; i < BUF_BYTES; i++) mem_q[i] <= 8'h00;
    end else if (clear_i) begin
      fill_q <= '0;
    end else if (push_i) begin
      for (int j = 0; j < RD_BYTES; j++) begin
        if (int'(fill_q) + j < BUF_BYTES) mem_q[int'(fill_q) + j] <= push_data_i[j*8 +: 8];
      end
      fill_q <= fill_q + FILL_W'(RD_BYTES);
    end else if (pop_i) begin
      // shift remaining bytes down to index 0
      for (int i = 0; i < BUF_BYTES; i++) begin
        if (i + int'(pop_size_i) < BUF_BYTES) mem_q[i] <= mem_q[i + int'(pop_size_i)];
        else                                   mem_q[i] <= 8'h00;
      end
      fill_q <= fill_q - pop_size_i;
    end
  end

  generate
    for (genvar g = 0; g < BUF_BYTES; g++) begin : g_out
      assign data_o[g*8 +: 8] = mem_q[g];
    end
  endgenerate

  assign fill_o = fill_q;
endmodule

// File: rtl/p2m_irq_unit.sv
module p2m_irq_unit
  import p2m_dma_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  sts_t set_i,
  input  sts_t clr_i,
  input  sts_t mask_i,
  output sts_t sts_o,
  output logic irq_o
);
  sts_t sts_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_q <= '0;
    else         sts_q <= (sts_q & ~clr_i) | set_i;  // set wins over clear
  end

  assign sts_o = sts_q;
  assign irq_o = |(sts_q & mask_i);
endmodule

// File: rtl/p2m_dma.sv
module p2m_dma
  import p2m_dma_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned RD_BYTES  = 8,
  parameter int unsigned BUF_BYTES = 32,
  parameter int unsigned WR_CYC    = 3,
  parameter int unsigned PEND_W    = 4,
  localparam int unsigned FILL_W   = $clog2(BUF_BYTES + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [AW-1:0]          addr_i,
  input  logic [LEN_W-1:0]       len_i,
  input  logic                   req_i,
  input  logic                   done_ni,
  output logic                   prd_en_o,
  input  logic [RD_BYTES*8-1:0]  prd_data_i,
  output logic                   mwr_valid_o,
  output logic [AW-1:0]          mwr_addr_o,
  output logic [FILL_W-1:0]      mwr_size_o,
  output logic [BUF_BYTES*8-1:0] mwr_data_o,
  input  logic [2:0]             irq_mask_i,
  input  logic [2:0]             sts_clr_i,
  output logic [2:0]             sts_o,
  output logic                   irq_o
);
  localparam int unsigned OFF_W  = $clog2(BUF_BYTES);
  localparam int unsigned BUSY_W = $clog2(WR_CYC + 1);

  logic              req_rise, done_fall;
  logic              running_q, done_seen_q, first_q;
  logic [AW-1:0]     addr_q;
  logic [LEN_W-1:0]  rem_q;
  logic [PEND_W-1:0] pend_q;
  logic [BUSY_W-1:0] busy_q;
  logic [FILL_W-1:0] fill;
  logic [BUF_BYTES*8-1:0] buf_data;

  logic              launch, bus_free, final_c, wr_fire, rd_fire, stop_fire, req_take;
  logic [FILL_W-1:0] lead_size, wr_size;
  sts_t              sts_set;

  p2m_edge_det #(.RISE(1'b1)) u_req_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .sig_i(req_i), .pulse_o(req_rise)
  );

  p2m_edge_det #(.RISE(1'b0)) u_done_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .sig_i(done_ni), .pulse_o(done_fall)
  );

  p2m_pack_buf #(.RD_BYTES(RD_BYTES), .BUF_BYTES(BUF_BYTES)) u_buf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (launch),
    .push_i     (rd_fire),
    .push_data_i(prd_data_i),
    .pop_i      (wr_fire),
    .pop_size_i (wr_size),
    .fill_o     (fill),
    .data_o     (buf_data)
  );

  always_comb begin
    launch    = start_i && !running_q;
    bus_free  = (busy_q == '0);
    final_c   = (rem_q == '0) || done_seen_q;
    wr_fire   = running_q && bus_free &&
                (final_c ? (fill != '0) : (fill == FILL_W'(BUF_BYTES)));
    stop_fire = running_q && bus_free && final_c && (fill == '0);
    rd_fire   = running_q && bus_free && !final_c &&
                (fill != FILL_W'(BUF_BYTES)) && (pend_q != '0);
    req_take  = req_rise && running_q && !done_seen_q;
    // first write stops at the next burst boundary
    lead_size = FILL_W'(BUF_BYTES) - FILL_W'(addr_q[OFF_W-1:0]);
    if (final_c)      wr_size = fill;
    else if (first_q) wr_size = lead_size;
    else              wr_size = FILL_W'(BUF_BYTES);
    sts_set = '0;
    if (stop_fire) begin
      sts_set[ST_STOP] = 1'b1;
      if (done_seen_q) sts_set[ST_XEND] = 1'b1;
      else             sts_set[ST_LEN]  = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      running_q   <= 1'b0;
      done_seen_q <= 1'b0;
      first_q     <= 1'b0;
      addr_q      <= '0;
      rem_q       <= '0;
      pend_q      <= '0;
      busy_q      <= '0;
    end else if (launch) begin
      running_q   <= 1'b1;
      done_seen_q <= 1'b0;
      first_q     <= 1'b1;
      addr_q      <= addr_i;
      rem_q       <= len_i;
      pend_q      <= '0;
      busy_q      <= '0;
    end else begin
      if (running_q && done_fall) done_seen_q <= 1'b1;
      pend_q <= pend_q + PEND_W'(req_take) - PEND_W'(rd_fire);
      if (rd_fire) rem_q <= rem_q - LEN_W'(RD_BYTES);
      if (wr_fire) begin
        addr_q  <= addr_q + AW'(wr_size);
        first_q <= 1'b0;
        busy_q  <= BUSY_W'(WR_CYC - 1);
      end else if (busy_q != '0) begin
        busy_q <= busy_q - 1'b1;
      end
      if (stop_fire) begin
        running_q   <= 1'b0;
        done_seen_q <= 1'b0;
        pend_q      <= '0;
      end
    end
  end

  p2m_irq_unit u_irq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (sts_set),
    .clr_i (sts_clr_i),
    .mask_i(irq_mask_i),
    .sts_o (sts_o),
    .irq_o (irq_o)
  );

  assign prd_en_o    = rd_fire;
  assign mwr_valid_o = wr_fire;
  assign mwr_addr_o  = addr_q;
  assign mwr_size_o  = wr_size;
  assign mwr_data_o  = buf_data;
endmodule

// File: rtl/p2m_dma_chk.sv
module p2m_dma_chk
  import p2m_dma_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned RD_BYTES  = 8,
  parameter int unsigned BUF_BYTES = 32,
  parameter int unsigned WR_CYC    = 3,
  localparam int unsigned FILL_W   = $clog2(BUF_BYTES + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [AW-1:0]     addr_i,
  input logic [LEN_W-1:0]  len_i,
  input logic              prd_en_o,
  input logic              mwr_valid_o,
  input logic [AW-1:0]     mwr_addr_o,
  input logic [FILL_W-1:0] mwr_size_o,
  input logic [2:0]        sts_clr_i,
  input logic [2:0]        sts_o
);
  logic [AW-1:0] nxt_q;
  logic          seen_q, quiet_q, stop_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nxt_q    <= '0;
      seen_q   <= 1'b0;
      quiet_q  <= 1'b0;
      stop_d_q <= 1'b0;
    end else begin
      stop_d_q <= sts_o[ST_STOP];
      if (start_i) begin
        seen_q  <= 1'b0;
        quiet_q <= 1'b0;
      end else begin
        if (mwr_valid_o) begin
          seen_q <= 1'b1;
          nxt_q  <= mwr_addr_o + AW'(mwr_size_o);
        end
        if (sts_o[ST_STOP] && !stop_d_q) quiet_q <= 1'b1;
      end
    end
  end

  // R1
  one_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(prd_en_o && mwr_valid_o));

  // R3
  size_rng_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mwr_valid_o |-> (mwr_size_o != '0) && (int'(mwr_size_o) <= BUF_BYTES) &&
                    (int'(mwr_size_o) % RD_BYTES == 0));

  // R4
  addr_cont_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mwr_valid_o && seen_q) |-> (mwr_addr_o == nxt_q));

  // R6
  quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quiet_q |-> !(prd_en_o || mwr_valid_o));

  // R7
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~sts_o) & $past(sts_o) & ~$past(sts_clr_i)) == 3'b000);

  // R5
  cfg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> (len_i != '0) && (int'(len_i) % RD_BYTES == 0) &&
                (int'(addr_i[2:0]) % RD_BYTES == 0));

  generate
    if (WR_CYC > 1) begin : g_gap
      // R8
      wr_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mwr_valid_o |=> !(prd_en_o || mwr_valid_o));
    end
  endgenerate
endmodule

bind p2m_dma p2m_dma_chk #(
  .AW(AW), .LEN_W(LEN_W), .RD_BYTES(RD_BYTES), .BUF_BYTES(BUF_BYTES), .WR_CYC(WR_CYC)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .addr_i     (addr_i),
  .len_i      (len_i),
  .prd_en_o   (prd_en_o),
  .mwr_valid_o(mwr_valid_o),
  .mwr_addr_o (mwr_addr_o),
  .mwr_size_o (mwr_size_o),
  .sts_clr_i  (sts_clr_i),
  .sts_o      (sts_o)
);

// File: tb/sim_p2m_dma.sv
`timescale 1ns/1ps
module sim_p2m_dma;
  localparam int AW = 32, LEN_W = 16, RDB = 8, BUFB = 32, FILL_W = 6;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0, req_i = 1'b0, done_ni = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic [LEN_W-1:0] len_i = '0;
  logic prd_en_o, mwr_valid_o, irq_o;
  logic [RDB*8-1:0] prd_data_i;
  logic [AW-1:0] mwr_addr_o;
  logic [FILL_W-1:0] mwr_size_o;
  logic [BUFB*8-1:0] mwr_data_o;
  logic [2:0] irq_mask_i = 3'b000, sts_clr_i = 3'b000, sts_o;

  always #4 clk = ~clk;

  p2m_dma u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .addr_i(addr_i), .len_i(len_i),
    .req_i(req_i), .done_ni(done_ni), .prd_en_o(prd_en_o), .prd_data_i(prd_data_i),
    .mwr_valid_o(mwr_valid_o), .mwr_addr_o(mwr_addr_o), .mwr_size_o(mwr_size_o),
    .mwr_data_o(mwr_data_o), .irq_mask_i(irq_mask_i), .sts_clr_i(sts_clr_i),
    .sts_o(sts_o), .irq_o(irq_o)
  );

  int n_chk = 0, n_fail = 0, strm = 0, rd_cnt = 0, cyc = 0;

  typedef struct { logic [AW-1:0] a; int sz; int base; string tag; } exp_t;
  exp_t sb[$];

  always_comb
    for (int j = 0; j < RDB; j++) prd_data_i[j*8 +: 8] = 8'(strm + j);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (prd_en_o) begin
      strm   <= strm + RDB;
      rd_cnt <= rd_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_ni && mwr_valid_o) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R6", "unexpected write addr", longint'(mwr_addr_o), 0);
      end else begin
        exp_t e;
        int bad;
        e = sb.pop_front();
        bad = -1;
        chk(mwr_addr_o == e.a, e.tag, "write addr", longint'(mwr_addr_o), longint'(e.a));
        chk(int'(mwr_size_o) == e.sz, e.tag, "write size", longint'(mwr_size_o), e.sz);
        for (int i = 0; i < e.sz && i < BUFB; i++)
          if (bad < 0 && mwr_data_o[i*8 +: 8] != 8'(e.base + i)) bad = i;
        chk(bad < 0, "R4", "write data byte index (actual=first bad)", bad, -1);
      end
    end
  end

  // driver model: pushes expected memory writes for one run
  task automatic plan_run(input logic [AW-1:0] a0, input int nrd, input bit done_end,
                          input string tag);
    int fill = 0, pos = strm, sz;
    bit first = 1'b1;
    logic [AW-1:0] a = a0;
    for (int r = 0; r < nrd; r++) begin
      fill += RDB;
      if ((r < nrd - 1 || done_end) && fill == BUFB) begin
        sz = first ? BUFB - int'(a % BUFB) : BUFB;
        sb.push_back('{a, sz, pos, tag});
        a += AW'(sz); pos += sz; fill -= sz; first = 1'b0;
      end
    end
    if (fill > 0) sb.push_back('{a, fill, pos, tag});
  endtask

  task automatic start_run(input logic [AW-1:0] a, input int len);
    @(negedge clk);
    addr_i = a; len_i = LEN_W'(len); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic pulse_req(input int hi, input int lo);
    @(negedge clk);
    req_i = 1'b1;
    repeat (hi) @(negedge clk);
    req_i = 1'b0;
    repeat (lo - 1) @(negedge clk);
  endtask

  task automatic wait_stop(input string tag);
    int t = 0;
    while (!sts_o[0] && t < 2000) begin
      @(negedge clk);
      t++;
    end
    chk(sts_o[0], tag, "channel stopped", longint'(sts_o), 1);
  endtask

  task automatic clear_sts();
    @(negedge clk);
    sts_clr_i = 3'b111;
    @(negedge clk);
    sts_clr_i = 3'b000;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    int r0;
    repeat (3) @(negedge clk);
    // R7 reset state
    chk(sts_o == 3'b000 && irq_o == 1'b0, "R7", "reset status/irq", longint'({irq_o, sts_o}), 0);
    chk(!mwr_valid_o && !prd_en_o, "R1", "idle at reset", longint'({mwr_valid_o, prd_en_o}), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    // aligned run, long first request (R9), R2/R3/R5
    plan_run(32'h1000, 8, 1'b0, "R3");
    start_run(32'h1000, 64);
    r0 = rd_cnt;
    pulse_req(6, 3);
    repeat (7) pulse_req(1, 4);
    wait_stop("R5");
    chk(rd_cnt - r0 == 8, "R9", "reads for 8 edges, first held high", rd_cnt - r0, 8);
    chk(sts_o == 3'b101, "R5", "status after length end", longint'(sts_o), 5);
    chk(irq_o == 1'b0, "R7", "irq with mask 000", irq_o, 0);
    irq_mask_i = 3'b010; #1;
    chk(irq_o == 1'b0, "R7", "stopped bit set but masked", irq_o, 0);
    irq_mask_i = 3'b100; #1;
    chk(irq_o == 1'b1, "R7", "length source enabled", irq_o, 1);
    irq_mask_i = 3'b000;
    @(negedge clk);
    sts_clr_i = 3'b100;
    @(negedge clk);
    sts_clr_i = 3'b000;
    chk(sts_o == 3'b001, "R7", "write-one-to-clear bit2 only", longint'(sts_o), 1);
    chk(sb.size() == 0, "R4", "all aligned writes seen", sb.size(), 0);
    clear_sts();

    // unaligned start, back-to-back requests queued behind writes (R2, R8)
    plan_run(32'h2008, 10, 1'b0, "R2");
    start_run(32'h2008, 80);
    r0 = rd_cnt;
    repeat (10) pulse_req(1, 1);
    wait_stop("R8");
    chk(rd_cnt - r0 == 10, "R8", "queued requests all served once", rd_cnt - r0, 10);
    chk(sts_o == 3'b101, "R5", "status after unaligned run", longint'(sts_o), 5);
    chk(sb.size() == 0, "R2", "all unaligned writes seen", sb.size(), 0);
    clear_sts();

    // peripheral end mid-descriptor (R6)
    plan_run(32'h3010, 7, 1'b1, "R6");
    start_run(32'h3010, 256);
    r0 = rd_cnt;
    repeat (7) pulse_req(1, 3);
    repeat (30) @(negedge clk);
    done_ni = 1'b0;
    repeat (3) @(negedge clk);
    done_ni = 1'b1;
    wait_stop("R6");
    chk(sts_o == 3'b011, "R6", "status after peripheral end", longint'(sts_o), 3);
    irq_mask_i = 3'b010; #1;
    chk(irq_o == 1'b1, "R7", "peripheral-end source enabled", irq_o, 1);
    irq_mask_i = 3'b000;
    repeat (3) pulse_req(1, 3);
    repeat (20) @(negedge clk);
    chk(rd_cnt - r0 == 7, "R6", "requests after end ignored", rd_cnt - r0, 7);
    chk(sb.size() == 0, "R6", "flush write seen", sb.size(), 0);
    clear_sts();

    // length shorter than the request count (R5)
    plan_run(32'h4000, 2, 1'b0, "R5");
    start_run(32'h4000, 16);
    r0 = rd_cnt;
    repeat (4) pulse_req(1, 3);
    wait_stop("R5");
    repeat (10) @(negedge clk);
    chk(rd_cnt - r0 == 2, "R5", "reads limited by length", rd_cnt - r0, 2);
    chk(sts_o == 3'b101, "R5", "short run status", longint'(sts_o), 5);
    clear_sts();

    // done low before start, then rising: no effect (R9)
    done_ni = 1'b0;
    repeat (2) @(negedge clk);
    plan_run(32'h5000, 4, 1'b0, "R9");
    start_run(32'h5000, 32);
    r0 = rd_cnt;
    done_ni = 1'b1;
    repeat (4) pulse_req(1, 3);
    wait_stop("R9");
    chk(sts_o == 3'b101, "R9", "done level/rise ignored", longint'(sts_o), 5);
    chk(rd_cnt - r0 == 4, "R1", "one read per edge", rd_cnt - r0, 4);
    chk(sb.size() == 0, "R9", "single full write seen", sb.size(), 0);

    repeat (5) @(negedge clk);
    finish_run();
  end

  always @(negedge clk) begin
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cyc);
      finish_run();
    end
  end
endmodule